// File: doc/BRIEF.md
# Two-Wire Paged Memory Slave

This block is a serial slave for a two-wire bus (clock plus open-drain data). It gives a bus master read and write access to a byte space of 272 locations, laid out as 17 pages of 16 bytes. The master opens a transfer with a START condition and sends a slave address byte, which the block matches against a fixed device type and a chip select. For writes, a word address byte follows, then one or more data bytes. For reads, data comes back from an internal pointer, one byte after another for as long as the master acknowledges.

Both bus lines are synchronised to the system clock, and the edges, START and STOP are found on the sampled values. The data line is driven only low, through `sda_oe`. Storage sits outside the block, behind a synchronous port with a one-cycle read latency. Writes move the pointer within the current 16-byte page. Reads move it linearly through the whole space.

The protocol state machine has ten states. IDLE waits for START. DEV shifts in the slave address byte. DEV_ACK acknowledges it. WADDR shifts in the word address. WADDR_ACK acknowledges it. WDATA shifts in a data byte. WDATA_ACK acknowledges it. RD shifts a byte out. RD_MACK releases the line and samples the master's acknowledge. RD_NEXT waits for the clock fall that starts the next byte.

The transitions are:
- START from any state goes to DEV.
- STOP from any state goes to IDLE.
- DEV goes to DEV_ACK on a match and to IDLE otherwise.
- DEV_ACK goes to RD for a read and to WADDR for a write.
- WADDR goes to WADDR_ACK for an address in range and to IDLE otherwise.
- WADDR_ACK and WDATA_ACK go to WDATA.
- WDATA goes to WDATA_ACK.
- RD goes to RD_MACK after 8 bits.
- RD_MACK goes to RD_NEXT on an ACK and to IDLE on a NACK.
- RD_NEXT goes to RD.

Top module: `i2c_paged_slave`

## Requirements
- R1: The block reacts to the bus only after a START, seen as the data line falling while the clock is high. A STOP (data rising while the clock is high) returns it to idle. Bytes clocked without a START get no ACK and cause no memory access.
- R2: The slave address byte carries the device type in bits 7:4 (parameter, default 4'b1010) and the chip select in bits 3:2 (parameter, default 2'b00). Bit 1 is the word address bit 8, and bit 0 selects read (1) or write (0). A byte that matches is acknowledged. A byte that does not match gets no ACK and causes no memory access.
- R3: The block acknowledges a byte by holding the data line low for the whole ninth clock. It changes its data drive only while the clock is low.
- R4: The word address is formed from address-byte bit 1 (bit 8) and the word address byte (bits 7:0). An address of 272 or higher is not acknowledged and leaves the pointer unchanged.
- R5: Each data byte of a write is stored at the pointer location and acknowledged.
- R6: During a write the pointer advances only within its 16-byte page, wrapping from offset 15 to offset 0 of the same page. For example, 12 bytes written from offset 11 land in offsets 11 to 15 and then 0 to 6.
- R7: After a write closed by STOP, the pointer holds the location that follows the last byte written, with the page wrap applied.
- R8: A read returns the byte at the pointer, most significant bit first. The pointer then advances linearly, from 271 back to 0.
- R9: A master ACK after a read byte continues with the next location. A master NACK ends the read, and the block releases the data line.
- R10: The memory port gives one single-cycle write strobe per data byte stored and one read strobe per byte fetched. Read data is taken one cycle after the read strobe, and the two strobes are never high together.
- R11: After reset the data line is released, no strobe is issued, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low |
| mem_addr | output | 9 | Storage address, equal to the pointer |
| mem_we | output | 1 | Storage write strobe |
| mem_wdata | output | 8 | Storage write data |
| mem_re | output | 1 | Storage read strobe |
| mem_rdata | input | 8 | Storage read data, valid one cycle after mem_re |

## Verification
The hardest case to reach from the ports is the pointer crossing a boundary: the wrap inside a page during a write, and the wrap from the top of the space to address 0 during a read. Both appear only after a multi-byte transfer that starts at the right offset. The bench writes 12 bytes from offset 11 of page 3 and then reads the whole page back. It also writes two bytes into page 16, which uses address bit 8 carried in the slave address byte, and then reads four bytes from 270 so that the read runs across 271 into 0. A random read requires a repeated START in the middle of the write-address phase, and the bench produces one in every random read.

// File: rtl/i2c_paged_slave_pkg.sv
package i2c_paged_slave_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RD,
        ST_RD_MACK,
        ST_RD_NEXT
    } slv_state_e;

    typedef struct packed {
        logic load;
        logic inc_page;
        logic inc_lin;
    } ptr_cmd_t;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic scl_d;
    logic sda_d;
    logic scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_sync[SYNC_STAGES-1];
            sda_d    <= sda_sync[SYNC_STAGES-1];
        end
    end

    assign scl_now   = scl_sync[SYNC_STAGES-1];
    assign sda_s     = sda_sync[SYNC_STAGES-1];
    assign scl_rise  = scl_now & ~scl_d;
    assign scl_fall  = ~scl_now & scl_d;
    assign start_det = scl_now & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_now & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr
    import i2c_paged_slave_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int NUM_PAGES  = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  ptr_cmd_t cmd,
    input  logic [$clog2(PAGE_BYTES*NUM_PAGES)-1:0] load_val,
    output logic [$clog2(PAGE_BYTES*NUM_PAGES)-1:0] ptr
);
    localparam int MEM_BYTES = PAGE_BYTES * NUM_PAGES;
    localparam int AW        = $clog2(MEM_BYTES);
    localparam int OFF_W     = $clog2(PAGE_BYTES);

    logic [AW-1:0]    ptr_q;
    logic [OFF_W-1:0] off_next;
    logic [AW-1:0]    lin_next;

    assign off_next = ptr_q[OFF_W-1:0] + 1'b1;
    assign lin_next = (ptr_q == AW'(MEM_BYTES - 1)) ? '0 : ptr_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (cmd.load) begin
            ptr_q <= load_val;
        end else if (cmd.inc_page) begin
            ptr_q <= {ptr_q[AW-1:OFF_W], off_next};
        end else if (cmd.inc_lin) begin
            ptr_q <= lin_next;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_paged_slave_pkg::*;
#(
    parameter int         AW        = 9,
    parameter int         MEM_BYTES = 272,
    parameter logic [3:0] DEV_ID    = 4'b1010,
    parameter logic [1:0] CHIP_SEL  = 2'b00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    mem_rdata,
    output logic          mem_we,
    output logic          mem_re,
    output logic [7:0]    mem_wdata,
    output ptr_cmd_t      ptr_cmd,
    output logic [AW-1:0] ptr_val,
    output logic          sda_oe
);
    slv_state_e state_q, state_d;

    logic [7:0] rx_sr;
    logic [7:0] tx_sr;
    logic [2:0] bit_cnt;
    logic       ack_ph;
    logic       rw_q;
    logic       a8_q;
    logic       rd_wait;

    logic [7:0] rx_byte;
    logic       byte_done;
    logic       dev_match;
    logic [8:0] full_addr;
    logic       addr_ok;

    assign rx_byte   = {rx_sr[6:0], sda_s};
    assign byte_done = scl_rise && (bit_cnt == 3'd7);
    assign dev_match = (rx_byte[7:4] == DEV_ID) && (rx_byte[3:2] == CHIP_SEL);
    assign full_addr = {a8_q, rx_byte};
    assign addr_ok   = (int'(full_addr) < MEM_BYTES);
    assign ptr_val   = full_addr[AW-1:0];
    assign mem_wdata = rx_byte;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and memory/pointer strobes
    always_comb begin
        state_d = state_q;
        mem_we  = 1'b0;
        mem_re  = 1'b0;
        ptr_cmd = '0;
        if (start_det) begin
            state_d = ST_DEV;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_DEV: begin
                    if (byte_done) begin
                        if (dev_match) begin
                            state_d = ST_DEV_ACK;
                            if (rx_byte[0]) begin
                                mem_re          = 1'b1;
                                ptr_cmd.inc_lin = 1'b1;
                            end
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall && ack_ph) state_d = rw_q ? ST_RD : ST_WADDR;
                end
                ST_WADDR: begin
                    if (byte_done) begin
                        if (addr_ok) begin
                            ptr_cmd.load = 1'b1;
                            state_d      = ST_WADDR_ACK;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall && ack_ph) state_d = ST_WDATA;
                end
                ST_WDATA: begin
                    if (byte_done) begin
                        mem_we           = 1'b1;
                        ptr_cmd.inc_page = 1'b1;
                        state_d          = ST_WDATA_ACK;
                    end
                end
                ST_RD: begin
                    if (byte_done) state_d = ST_RD_MACK;
                end
                ST_RD_MACK: begin
                    if (scl_rise && ack_ph) begin
                        if (!sda_s) begin
                            mem_re          = 1'b1;
                            ptr_cmd.inc_lin = 1'b1;
                            state_d         = ST_RD_NEXT;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_RD_NEXT: begin
                    if (scl_fall) state_d = ST_RD;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe  <= 1'b0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            bit_cnt <= '0;
            ack_ph  <= 1'b0;
            rw_q    <= 1'b0;
            a8_q    <= 1'b0;
            rd_wait <= 1'b0;
        end else begin
            rd_wait <= mem_re;
            if (start_det || stop_det) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                ack_ph  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sr   <= rx_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                            ack_ph  <= 1'b0;
                            if (byte_done && state_q == ST_DEV) begin
                                rw_q <= rx_byte[0];
                                a8_q <= rx_byte[1];
                            end
                        end
                    end
                    ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            if (!ack_ph) begin
                                sda_oe <= 1'b1;
                                ack_ph <= 1'b1;
                            end else begin
                                sda_oe  <= (state_q == ST_DEV_ACK) && rw_q && !tx_sr[7];
                                ack_ph  <= 1'b0;
                                bit_cnt <= '0;
                            end
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            sda_oe <= !tx_sr[6];
                            tx_sr  <= {tx_sr[6:0], 1'b0};
                        end
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            ack_ph  <= 1'b0;
                        end
                    end
                    ST_RD_MACK: begin
                        if (scl_fall && !ack_ph) begin
                            sda_oe <= 1'b0;
                            ack_ph <= 1'b1;
                        end
                    end
                    ST_RD_NEXT: begin
                        if (scl_fall) begin
                            sda_oe  <= !tx_sr[7];
                            bit_cnt <= '0;
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
            if (rd_wait) tx_sr <= mem_rdata;
        end
    end

endmodule

// File: rtl/i2c_paged_slave.sv
module i2c_paged_slave
    import i2c_paged_slave_pkg::*;
#(
    parameter int         PAGE_BYTES  = 16,
    parameter int         NUM_PAGES   = 17,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_ID      = 4'b1010,
    parameter logic [1:0] CHIP_SEL    = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [$clog2(PAGE_BYTES*NUM_PAGES)-1:0] mem_addr,
    output logic       mem_we,
    output logic [7:0] mem_wdata,
    output logic       mem_re,
    input  logic [7:0] mem_rdata
);
    localparam int MEM_BYTES = PAGE_BYTES * NUM_PAGES;
    localparam int AW        = $clog2(MEM_BYTES);

    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    ptr_cmd_t      ptr_cmd;
    logic [AW-1:0] ptr_val;

    i2c_line_cond #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slave_fsm #(
        .AW        (AW),
        .MEM_BYTES (MEM_BYTES),
        .DEV_ID    (DEV_ID),
        .CHIP_SEL  (CHIP_SEL)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .ptr_cmd   (ptr_cmd),
        .ptr_val   (ptr_val),
        .sda_oe    (sda_oe)
    );

    i2c_addr_ptr #(
        .PAGE_BYTES (PAGE_BYTES),
        .NUM_PAGES  (NUM_PAGES)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (ptr_cmd),
        .load_val (ptr_val),
        .ptr      (mem_addr)
    );

endmodule

// File: rtl/i2c_paged_slave_chk.sv
module i2c_paged_slave_chk #(
    parameter int PAGE_BYTES = 16,
    parameter int NUM_PAGES  = 17
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic mem_we,
    input logic mem_re,
    input logic [$clog2(PAGE_BYTES*NUM_PAGES)-1:0] mem_addr
);
    localparam int MEM_BYTES = PAGE_BYTES * NUM_PAGES;
    localparam int AW        = $clog2(MEM_BYTES);
    localparam int OFF_W     = $clog2(PAGE_BYTES);

    // R3: drive changes only while the clock line is low
    assert_sda_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R4: pointer never leaves the space
    assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mem_addr) < MEM_BYTES);

    // R6: a write moves the pointer to the next offset of the same page
    assert_page_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr[AW-1:OFF_W] == $past(mem_addr[AW-1:OFF_W])) &&
                   (mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1)));

    // R8: a fetch moves the pointer linearly with wrap to 0
    assert_lin_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> mem_addr == (($past(mem_addr) == AW'(MEM_BYTES - 1)) ? '0
                                 : AW'($past(mem_addr) + 1'b1)));

    // R10: strobes exclusive and single-cycle
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_we_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

endmodule

bind i2c_paged_slave i2c_paged_slave_chk #(
    .PAGE_BYTES (PAGE_BYTES),
    .NUM_PAGES  (NUM_PAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr)
);

// File: tb/i2c_paged_slave_bench.sv
module i2c_paged_slave_bench;
    localparam int Q     = 8;
    localparam int NLOC  = 272;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [8:0] mem_addr;
    logic       mem_we;
    logic [7:0] mem_wdata;
    logic       mem_re;
    logic [7:0] mem_rdata;

    logic [7:0] store [NLOC];
    logic [7:0] expv  [NLOC];
    int         exp_ptr = 0;
    int         checks = 0;
    int         errors = 0;
    int         we_count = 0;
    int         re_count = 0;
    int         we_double = 0;
    logic       we_prev = 1'b0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_paged_slave u_i2c_paged_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLOC; i++) store[i] <= 8'(i * 7 + 3);
            mem_rdata <= '0;
            we_prev   <= 1'b0;
        end else begin
            if (mem_we) store[mem_addr] <= mem_wdata;
            if (mem_re) mem_rdata <= store[mem_addr];
            if (mem_we) we_count <= we_count + 1;
            if (mem_re) re_count <= re_count + 1;
            if (mem_we && we_prev) we_double <= we_double + 1;
            we_prev <= mem_we;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expd);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, expd);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    function automatic int page_next(input int a);
        return (a & ~15) | ((a + 1) & 15);
    endfunction

    function automatic int lin_next(input int a);
        return (a == NLOC - 1) ? 0 : a + 1;
    endfunction

    function automatic logic [7:0] dev_byte(input bit a8, input bit rd);
        return {4'b1010, 2'b00, a8, rd};
    endfunction

    task automatic bus_start();
        qwait(); sda_m = 1'b1;
        qwait(); scl_m = 1'b1;
        qwait(); sda_m = 1'b0;
        qwait(); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        qwait(); sda_m = 1'b0;
        qwait(); scl_m = 1'b1;
        qwait(); sda_m = 1'b1;
        qwait(); qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) begin
            qwait(); sda_m = b[i];
            qwait(); scl_m = 1'b1;
            qwait(); qwait(); scl_m = 1'b0;
        end
        qwait(); sda_m = 1'b1;
        qwait(); scl_m = 1'b1;
        qwait(); s1 = sda_line;
        qwait(); s2 = sda_line;
        scl_m = 1'b0;
        acked = !s1 && !s2;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait(); qwait(); scl_m = 1'b1;
            qwait(); b[i] = sda_line;
            qwait(); scl_m = 1'b0;
        end
        qwait(); sda_m = !mack;
        qwait(); scl_m = 1'b1;
        qwait(); qwait(); scl_m = 1'b0;
        qwait(); sda_m = 1'b1;
    endtask

    task automatic set_addr(input int a, output bit ok);
        bit ack;
        bus_start();
        send_byte(dev_byte(a[8], 1'b0), ack);
        check(ack, "R2 write address byte ACK", int'(ack), 1);
        send_byte(a[7:0], ok);
    endtask

    task automatic write_run(input int a, input int n, input int base);
        bit ack;
        int w0;
        set_addr(a, ack);
        check(ack, "R3 word address ACK", int'(ack), 1);
        exp_ptr = a;
        w0 = we_count;
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'(base + i * 13);
            send_byte(v, ack);
            check(ack, "R5 data byte ACK", int'(ack), 1);
            expv[exp_ptr] = v;
            exp_ptr = page_next(exp_ptr);
        end
        bus_stop();
        check(we_count - w0 == n, "R10 write strobe count", we_count - w0, n);
    endtask

    task automatic read_bytes(input int n, input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            check(b == expv[exp_ptr], req, int'(b), int'(expv[exp_ptr]));
            exp_ptr = lin_next(exp_ptr);
        end
        qwait();
        check(sda_oe == 1'b0, "R9 data line released after NACK", int'(sda_oe), 0);
        bus_stop();
    endtask

    task automatic current_read(input int n, input string req);
        bit ack;
        bus_start();
        send_byte(dev_byte(1'b0, 1'b1), ack);
        check(ack, "R2 read address byte ACK", int'(ack), 1);
        read_bytes(n, req);
    endtask

    task automatic random_read(input int a, input int n, input string req);
        bit ack;
        set_addr(a, ack);
        check(ack, "R4 word address ACK", int'(ack), 1);
        exp_ptr = a;
        bus_start();
        send_byte(dev_byte(1'b0, 1'b1), ack);
        check(ack, "R2 read address byte ACK", int'(ack), 1);
        read_bytes(n, req);
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R11 data line released at reset", int'(sda_oe), 0);
        check(we_count == 0 && re_count == 0, "R11 no strobes at reset", we_count + re_count, 0);
        current_read(1, "R11 pointer starts at 0");
    endtask

    task automatic t_no_start();
        bit ack;
        int c0;
        c0 = we_count + re_count;
        qwait(); scl_m = 1'b0;
        send_byte(dev_byte(1'b0, 1'b0), ack);
        check(!ack, "R1 byte without START not acknowledged", int'(ack), 0);
        qwait(); scl_m = 1'b1;
        qwait();
        check(we_count + re_count == c0, "R1 no access without START", we_count + re_count, c0);
    endtask

    task automatic t_dev_mismatch();
        bit ack;
        int c0;
        c0 = we_count + re_count;
        bus_start();
        send_byte(8'hB0, ack);
        check(!ack, "R2 wrong device type NACK", int'(ack), 0);
        bus_stop();
        bus_start();
        send_byte(8'hA5, ack);
        check(!ack, "R2 wrong chip select NACK", int'(ack), 0);
        bus_stop();
        check(we_count + re_count == c0, "R2 no access on mismatch", we_count + re_count, c0);
    endtask

    task automatic t_byte_write();
        write_run(9'h005, 1, 8'h3C);
        random_read(9'h005, 1, "R5 single byte stored");
    endtask

    task automatic t_page_wrap();
        write_run(9'h03B, 12, 8'hA0);
        check(we_double == 0, "R10 write strobe single cycle", we_double, 0);
        check(exp_ptr == 9'h037, "R6 model pointer after wrap", exp_ptr, 9'h037);
        current_read(1, "R7 pointer after page write");
        random_read(9'h030, 16, "R6 page contents after wrap");
    endtask

    task automatic t_high_page();
        write_run(9'h10F, 2, 8'h51);
        random_read(9'h10E, 4, "R8 sequential read across 271 to 0");
    endtask

    task automatic t_bad_addr();
        bit ack;
        int w0;
        w0 = we_count;
        set_addr(9'h110, ack);
        check(!ack, "R4 address 272 not acknowledged", int'(ack), 0);
        bus_stop();
        set_addr(9'h1FF, ack);
        check(!ack, "R4 address 511 not acknowledged", int'(ack), 0);
        bus_stop();
        check(we_count == w0, "R4 no write on bad address", we_count, w0);
        current_read(2, "R4 pointer unchanged by bad address");
    endtask

    initial begin
        for (int i = 0; i < NLOC; i++) expv[i] = 8'(i * 7 + 3);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_no_start();
        t_dev_mismatch();
        t_byte_write();
        t_page_wrap();
        t_high_page();
        t_bad_addr();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule